// File: doc/BRIEF.md
# Paired Stack Pointer Sequencer

This block keeps two byte-wide stack pointers into a 256-byte data RAM and drives that RAM's single port for every stack operation. The call stack pointer handles subroutine calls, interrupt entry and the two kinds of return. Each of these moves a two-byte frame that holds a 14-bit program counter and the carry and zero flags. The call stack grows upward, and each byte is written before the pointer advances. The operand stack pointer handles single-byte pushes and pops of the accumulator. That stack grows downward: a push moves the pointer down before it writes, and a pop reads before it moves the pointer up.

The instruction decoder presents one command at a time with `cmd_valid` and `cmd_op`, together with the program counter, the flags and the accumulator byte. The block sets the RAM address, write data and read strobe over one or two cycles. It then raises `done` for one cycle and returns any restored value together with a load strobe. The RAM has a synchronous read port: data addressed in one cycle is presented on `ram_rdata` in the next cycle. `busy` stays high during every multi-cycle sequence. A command presented while `busy` is high is dropped.

Top module: `stack_pointer_pair`

## Requirements
- R1: After reset, both pointers are 0x00. `busy`, `done`, `ram_we`, `ram_re` and all result strobes are low. The first frame save therefore writes address 0x00, and the first push writes address 0xFF.
- R2: A call (op 1) or an interrupt entry (op 0) writes two bytes in consecutive cycles. The first byte is {carry, zero, PC[13:8]} (bit 7 carry, bit 6 zero) and goes to the call pointer address. The second byte is PC[7:0] and goes to that address plus one. The pointer ends 2 higher, modulo 256.
- R3: A return (op 2) or an interrupt return (op 3) reads the call pointer minus 1 and then the call pointer minus 2, in consecutive cycles. The pointer ends 2 lower. `pc_out` becomes {first-byte[5:0], second-byte}, and `pc_load` pulses.
- R4: A plain return (op 2) leaves `flag_load` low and leaves `carry_out` and `zero_out` unchanged.
- R5: An interrupt return (op 3) loads `carry_out` and `zero_out` from bits 7 and 6 of the first frame byte, with `flag_load` high. It also pulses `irq_on` in the same cycle as `pc_load`.
- R6: An interrupt entry pulses `irq_off` together with `done`. A call does not.
- R7: A push (op 4) first decrements the operand pointer and then writes `acc_in` at the new value. A push at 0x00 writes 0xFF.
- R8: A pop (op 5) reads at the operand pointer and then increments it. The byte read appears on `acc_out` with `acc_load` high.
- R9: An exchange (op 7) completes in one cycle. `acc_out` returns the old operand pointer with `acc_load` high, and the pointer takes `acc_in`.
- R10: A set-call-pointer (op 6) completes in one cycle and loads the call pointer from `acc_in`. It makes no RAM access and does not pulse `acc_load`, so the call pointer is never read back.
- R11: Cycles from command acceptance to `done` are 3 for a frame save, 4 for a frame restore, 2 for a push, 3 for a pop and 1 for an exchange or a set-call-pointer. `busy` is high on every cycle before `done` and low while `done` is high. A command presented while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present, accepted when not busy |
| cmd_op | input | 3 | Operation code (0 entry, 1 call, 2 return, 3 interrupt return, 4 push, 5 pop, 6 set call pointer, 7 exchange) |
| pc_in | input | 14 | Program counter to save |
| carry_in | input | 1 | Carry flag to save |
| zero_in | input | 1 | Zero flag to save |
| acc_in | input | 8 | Accumulator byte |
| ram_rdata | input | 8 | RAM read data, one cycle after the read strobe |
| ram_addr | output | 8 | RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write data |
| pc_out | output | 14 | Restored program counter |
| carry_out | output | 1 | Restored carry flag |
| zero_out | output | 1 | Restored zero flag |
| pc_load | output | 1 | `pc_out` valid pulse |
| flag_load | output | 1 | Flags valid pulse |
| acc_out | output | 8 | Popped byte or old operand pointer |
| acc_load | output | 1 | `acc_out` valid pulse |
| irq_off | output | 1 | Disable interrupts pulse |
| irq_on | output | 1 | Re-enable interrupts pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Operation complete pulse |

## Verification
The cycle-by-cycle checks cover the fixed RAM access patterns. Two consecutive writes must land on ascending addresses, and two consecutive reads on descending ones. No read and write happen together, and no access occurs outside a busy sequence. They also check how the strobes pair up: the interrupt strobes against the load strobes, flags left stable on a plain return, and `done` never together with `busy`. Only the bench's scenarios can show that the restored values match what was saved earlier, that the pointers wrap correctly at both ends, and that the exchange returns the right old pointer. They also show that a command issued while busy leaves no trace in later addresses, and that random mixes of the two stacks sharing one RAM stay consistent.

// File: rtl/spp_pkg.sv
package spp_pkg;

  typedef enum logic [2:0] {
    OP_IRQ_ENTER  = 3'd0,
    OP_CALL       = 3'd1,
    OP_RET        = 3'd2,
    OP_RET_IRQ    = 3'd3,
    OP_PUSH       = 3'd4,
    OP_POP        = 3'd5,
    OP_SET_CPTR   = 3'd6,
    OP_XCHG_OPTR  = 3'd7
  } spp_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE2,
    ST_FIN,
    ST_RD2,
    ST_RDLO,
    ST_RDHI,
    ST_POPW,
    ST_POPC
  } spp_st_e;

endpackage

// File: rtl/spp_ptr.sv
module spp_ptr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + 1'b1;
    else if (dec) q <= q - 1'b1;
  end

endmodule

// File: rtl/spp_ctrl.sv
module spp_ctrl
  import spp_pkg::*;
#(
  parameter int W   = 8,
  parameter int PCW = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [PCW-1:0] pc_in,
  input  logic           carry_in,
  input  logic           zero_in,
  input  logic [W-1:0]   acc_in,
  input  logic [W-1:0]   ram_rdata,
  input  logic [W-1:0]   cptr_q,
  input  logic [W-1:0]   optr_q,
  output logic           c_inc,
  output logic           c_dec,
  output logic           c_ld,
  output logic           o_inc,
  output logic           o_dec,
  output logic           o_ld,
  output logic [W-1:0]   ram_addr,
  output logic           ram_we,
  output logic           ram_re,
  output logic [W-1:0]   ram_wdata,
  output logic [PCW-1:0] pc_out,
  output logic           carry_out,
  output logic           zero_out,
  output logic           pc_load,
  output logic           flag_load,
  output logic [W-1:0]   acc_out,
  output logic           acc_load,
  output logic           irq_off,
  output logic           irq_on,
  output logic           busy,
  output logic           done
);

  localparam int HI_W  = PCW - W;
  localparam int C_BIT = W - 1;
  localparam int Z_BIT = W - 2;

  spp_st_e        state, nxt;
  spp_op_e        op_in, op_q;
  logic [PCW-1:0] hold_pc;
  logic [W-1:0]   lo_q;

  assign op_in = spp_op_e'(cmd_op);

  function automatic logic [W-1:0] pack_hi(input logic [PCW-1:0] pc,
                                           input logic c, input logic z);
    logic [W-1:0] b;
    b = '0;
    b[HI_W-1:0] = pc[PCW-1:W];
    b[C_BIT] = c;
    b[Z_BIT] = z;
    return b;
  endfunction

  always_comb begin
    nxt   = state;
    c_inc = 1'b0;
    c_dec = 1'b0;
    c_ld  = 1'b0;
    o_inc = 1'b0;
    o_dec = 1'b0;
    o_ld  = 1'b0;
    case (state)
      ST_IDLE: if (cmd_valid) begin
        case (op_in)
          OP_IRQ_ENTER, OP_CALL: begin c_inc = 1'b1; nxt = ST_SAVE2; end
          OP_RET, OP_RET_IRQ:    begin c_dec = 1'b1; nxt = ST_RD2;   end
          OP_PUSH:               begin o_dec = 1'b1; nxt = ST_FIN;   end
          OP_POP:                begin o_inc = 1'b1; nxt = ST_POPW;  end
          OP_SET_CPTR:           c_ld = 1'b1;
          default:               o_ld = 1'b1;
        endcase
      end
      ST_SAVE2: begin c_inc = 1'b1; nxt = ST_FIN; end
      ST_RD2:   begin c_dec = 1'b1; nxt = ST_RDLO; end
      ST_RDLO:  nxt = ST_RDHI;
      ST_POPW:  nxt = ST_POPC;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_CALL;
      hold_pc   <= '0;
      lo_q      <= '0;
      ram_addr  <= '0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      ram_wdata <= '0;
      pc_out    <= '0;
      carry_out <= 1'b0;
      zero_out  <= 1'b0;
      pc_load   <= 1'b0;
      flag_load <= 1'b0;
      acc_out   <= '0;
      acc_load  <= 1'b0;
      irq_off   <= 1'b0;
      irq_on    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= nxt;
      busy      <= (nxt != ST_IDLE);
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      pc_load   <= 1'b0;
      flag_load <= 1'b0;
      acc_load  <= 1'b0;
      irq_off   <= 1'b0;
      irq_on    <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= op_in;
          hold_pc <= pc_in;
          case (op_in)
            OP_IRQ_ENTER, OP_CALL: begin
              ram_addr  <= cptr_q;
              ram_we    <= 1'b1;
              ram_wdata <= pack_hi(pc_in, carry_in, zero_in);
            end
            OP_RET, OP_RET_IRQ: begin
              ram_addr <= cptr_q - 1'b1;
              ram_re   <= 1'b1;
            end
            OP_PUSH: begin
              ram_addr  <= optr_q - 1'b1;
              ram_we    <= 1'b1;
              ram_wdata <= acc_in;
            end
            OP_POP: begin
              ram_addr <= optr_q;
              ram_re   <= 1'b1;
            end
            OP_SET_CPTR: done <= 1'b1;
            default: begin
              acc_out  <= optr_q;
              acc_load <= 1'b1;
              done     <= 1'b1;
            end
          endcase
        end
        ST_SAVE2: begin
          ram_addr  <= cptr_q;
          ram_we    <= 1'b1;
          ram_wdata <= hold_pc[W-1:0];
        end
        ST_FIN: begin
          done    <= 1'b1;
          irq_off <= (op_q == OP_IRQ_ENTER);
        end
        ST_RD2: begin
          ram_addr <= cptr_q - 1'b1;
          ram_re   <= 1'b1;
        end
        ST_RDLO: lo_q <= ram_rdata;
        ST_RDHI: begin
          pc_out  <= {ram_rdata[HI_W-1:0], lo_q};
          pc_load <= 1'b1;
          done    <= 1'b1;
          if (op_q == OP_RET_IRQ) begin
            carry_out <= ram_rdata[C_BIT];
            zero_out  <= ram_rdata[Z_BIT];
            flag_load <= 1'b1;
            irq_on    <= 1'b1;
          end
        end
        ST_POPC: begin
          acc_out  <= ram_rdata;
          acc_load <= 1'b1;
          done     <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stack_pointer_pair.sv
module stack_pointer_pair #(
  parameter int W   = 8,
  parameter int PCW = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [PCW-1:0] pc_in,
  input  logic           carry_in,
  input  logic           zero_in,
  input  logic [W-1:0]   acc_in,
  input  logic [W-1:0]   ram_rdata,
  output logic [W-1:0]   ram_addr,
  output logic           ram_we,
  output logic           ram_re,
  output logic [W-1:0]   ram_wdata,
  output logic [PCW-1:0] pc_out,
  output logic           carry_out,
  output logic           zero_out,
  output logic           pc_load,
  output logic           flag_load,
  output logic [W-1:0]   acc_out,
  output logic           acc_load,
  output logic           irq_off,
  output logic           irq_on,
  output logic           busy,
  output logic           done
);

  logic [W-1:0] cptr_q, optr_q;
  logic c_inc, c_dec, c_ld, o_inc, o_dec, o_ld;

  spp_ptr #(.W(W)) u_cptr (
    .clk(clk), .rst(rst), .inc(c_inc), .dec(c_dec), .ld(c_ld),
    .ld_val(acc_in), .q(cptr_q)
  );

  spp_ptr #(.W(W)) u_optr (
    .clk(clk), .rst(rst), .inc(o_inc), .dec(o_dec), .ld(o_ld),
    .ld_val(acc_in), .q(optr_q)
  );

  spp_ctrl #(.W(W), .PCW(PCW)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pc_in(pc_in), .carry_in(carry_in), .zero_in(zero_in), .acc_in(acc_in),
    .ram_rdata(ram_rdata), .cptr_q(cptr_q), .optr_q(optr_q),
    .c_inc(c_inc), .c_dec(c_dec), .c_ld(c_ld),
    .o_inc(o_inc), .o_dec(o_dec), .o_ld(o_ld),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
    .pc_out(pc_out), .carry_out(carry_out), .zero_out(zero_out),
    .pc_load(pc_load), .flag_load(flag_load), .acc_out(acc_out),
    .acc_load(acc_load), .irq_off(irq_off), .irq_on(irq_on),
    .busy(busy), .done(done)
  );

endmodule

// File: rtl/spp_chk.sv
module spp_chk #(
  parameter int W   = 8,
  parameter int PCW = 14
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   ram_addr,
  input logic           ram_we,
  input logic           ram_re,
  input logic           carry_out,
  input logic           zero_out,
  input logic           pc_load,
  input logic           flag_load,
  input logic           irq_off,
  input logic           irq_on,
  input logic           busy,
  input logic           done
);

  AST_FRAME_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1)); // R2

  AST_RESTORE_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (ram_re && $past(ram_re)) |-> (ram_addr == $past(ram_addr) - 1'b1)); // R3

  AST_RET_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !flag_load) |-> ($stable(carry_out) && $stable(zero_out))); // R4

  AST_IRQ_ON_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
    irq_on |-> (pc_load && flag_load)); // R5

  AST_IRQ_OFF_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    irq_off |-> (done && !pc_load)); // R6

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re)); // R11

  AST_ACCESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |-> busy); // R11

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11

endmodule

bind stack_pointer_pair spp_chk #(.W(W), .PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
  .carry_out(carry_out), .zero_out(zero_out), .pc_load(pc_load),
  .flag_load(flag_load), .irq_off(irq_off), .irq_on(irq_on),
  .busy(busy), .done(done)
);

// File: tb/stack_pointer_pair_tb.sv
module stack_pointer_pair_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [13:0] pc_in;
  logic        carry_in, zero_in;
  logic [7:0]  acc_in;
  logic [7:0]  ram_rdata;
  logic [7:0]  ram_addr, ram_wdata, acc_out;
  logic        ram_we, ram_re;
  logic [13:0] pc_out;
  logic        carry_out, zero_out, pc_load, flag_load, acc_load;
  logic        irq_off, irq_on, busy, done;

  int total = 0;
  int bad = 0;

  logic [7:0] mem [256];
  logic [7:0] em  [256];
  logic [7:0] cpm, opm;

  always #2.5ns clk = ~clk;

  stack_pointer_pair u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pc_in(pc_in), .carry_in(carry_in), .zero_in(zero_in), .acc_in(acc_in),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .pc_out(pc_out), .carry_out(carry_out),
    .zero_out(zero_out), .pc_load(pc_load), .flag_load(flag_load),
    .acc_out(acc_out), .acc_load(acc_load), .irq_off(irq_off), .irq_on(irq_on),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return 3;
      3'd2, 3'd3: return 4;
      3'd4:       return 2;
      3'd5:       return 3;
      default:    return 1;
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input logic [13:0] pc, input logic c,
                     input logic z, input logic [7:0] acc, input bit intrude);
    int k = 0, nw = 0, nr = 0, nb = 0;
    logic [7:0] wa [4];
    logic [7:0] wd [4];
    logic [7:0] ra [4];
    logic pcl = 0, fl = 0, accl = 0, ion = 0, ioff = 0, c0, z0, cv, zv;
    logic [13:0] pcv = '0;
    logic [7:0] av = '0, b1, b2;
    cv = 0; zv = 0;
    for (int i = 0; i < 4; i++) begin wa[i] = '0; wd[i] = '0; ra[i] = '0; end
    c0 = carry_out; z0 = zero_out;
    cmd_valid = 1'b1; cmd_op = op; pc_in = pc; carry_in = c; zero_in = z; acc_in = acc;
    while (k < 8) begin
      @(negedge clk);
      k++;
      if (intrude && k == 1) begin cmd_op = 3'd4; acc_in = 8'h77; end
      else cmd_valid = 1'b0;
      if (ram_we && nw < 4) begin wa[nw] = ram_addr; wd[nw] = ram_wdata; nw++; end
      if (ram_re && nr < 4) begin ra[nr] = ram_addr; nr++; end
      if (busy) nb++;
      if (pc_load) begin pcl = 1; pcv = pc_out; end
      if (flag_load) fl = 1;
      cv = carry_out; zv = zero_out;
      if (acc_load) begin accl = 1; av = acc_out; end
      if (irq_on) ion = 1;
      if (irq_off) ioff = 1;
      if (done) break;
    end
    chk("R11 cycles to done", k, exp_cycles(op));
    chk("R11 busy cycles", nb, exp_cycles(op) - 1);
    case (op)
      3'd0, 3'd1: begin
        chk("R2 write count", nw, 2);
        chk("R2 first addr", wa[0], cpm);
        chk("R2 first byte", wd[0], {c, z, pc[13:8]});
        chk("R2 second addr", wa[1], 8'(cpm + 8'd1));
        chk("R2 second byte", wd[1], pc[7:0]);
        chk("R6 irq_off", ioff, (op == 3'd0));
        em[cpm] = {c, z, pc[13:8]};
        em[8'(cpm + 8'd1)] = pc[7:0];
        cpm = cpm + 8'd2;
      end
      3'd2, 3'd3: begin
        b2 = em[8'(cpm - 8'd1)];
        b1 = em[8'(cpm - 8'd2)];
        chk("R3 read count", nr, 2);
        chk("R3 first read addr", ra[0], 8'(cpm - 8'd1));
        chk("R3 second read addr", ra[1], 8'(cpm - 8'd2));
        chk("R3 pc_load", pcl, 1);
        chk("R3 pc value", pcv, {b1[5:0], b2});
        if (op == 3'd2) begin
          chk("R4 no flag_load", fl, 0);
          chk("R4 carry kept", cv, c0);
          chk("R4 zero kept", zv, z0);
          chk("R4 no irq_on", ion, 0);
        end else begin
          chk("R5 flag_load", fl, 1);
          chk("R5 carry", cv, b1[7]);
          chk("R5 zero", zv, b1[6]);
          chk("R5 irq_on", ion, 1);
        end
        cpm = cpm - 8'd2;
      end
      3'd4: begin
        chk("R7 write count", nw, 1);
        chk("R7 push addr", wa[0], 8'(opm - 8'd1));
        chk("R7 push data", wd[0], acc);
        opm = opm - 8'd1;
        em[opm] = acc;
      end
      3'd5: begin
        chk("R8 read count", nr, 1);
        chk("R8 pop addr", ra[0], opm);
        chk("R8 acc_load", accl, 1);
        chk("R8 pop data", av, em[opm]);
        opm = opm + 8'd1;
      end
      3'd6: begin
        chk("R10 no access", nw + nr, 0);
        chk("R10 no readback", accl, 0);
        cpm = acc;
      end
      default: begin
        chk("R9 no access", nw + nr, 0);
        chk("R9 acc_load", accl, 1);
        chk("R9 old pointer", av, opm);
        opm = acc;
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; em[i] = '0; end
    ram_rdata = '0;
    cpm = '0; opm = '0;
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; pc_in = '0;
    carry_in = 1'b0; zero_in = 1'b0; acc_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy low", busy, 0);
    chk("R1 done low", done, 0);
    chk("R1 no access", ram_we | ram_re, 0);
    chk("R1 strobes low", pc_load | flag_load | acc_load | irq_on | irq_off, 0);

    run(3'd4, '0, 0, 0, 8'hA5, 0);        // R1 R7 push at 0 -> 0xFF
    run(3'd1, 14'h3ABC, 1, 0, '0, 0);     // R1 first frame at 0x00
    run(3'd0, 14'h0123, 0, 1, '0, 1);     // R6 R11 entry with ignored push
    run(3'd3, '0, 0, 0, '0, 0);           // R5
    run(3'd2, '0, 1, 1, '0, 0);           // R4
    run(3'd5, '0, 0, 0, '0, 0);           // R8 pop from 0xFF
    run(3'd7, '0, 0, 0, 8'h40, 0);        // R9
    run(3'd6, '0, 0, 0, 8'hFF, 0);        // R10
    run(3'd1, 14'h2F0F, 1, 1, '0, 0);     // R2 wrap 0xFF -> 0x00
    run(3'd3, '0, 0, 0, '0, 0);           // R3 wrap back

    void'($urandom(32'h5A17));
    for (int n = 0; n < 400; n++) begin
      run(3'($urandom_range(0, 7)), 14'($urandom), 1'($urandom), 1'($urandom),
          8'($urandom), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule